// File: doc/BRIEF.md
# ModRM SIB Displacement Decoder

This block decodes the addressing bytes that follow the opcode of a variable-length instruction. It receives a window of raw instruction bytes, the offset of the byte that follows the opcode, a flag saying whether a ModRM byte is expected, the effective address size and a 64-bit mode flag. It fetches the ModRM byte and decides whether a SIB byte follows. It then sizes the displacement and extracts it, sign-extended to 32 bits.

A caller pulses `start_i` with its inputs valid. One cycle later the result appears with `done_o` high for exactly one cycle. The result is the ModRM and SIB values, their presence flags, the displacement size and value, a flag for instruction-pointer-relative addressing, and the offset of the first byte after the displacement. The immediate decoder downstream uses that offset. If any byte the rule needs lies at or beyond the valid window length, `err_o` is raised in place of a result. Opcode classification is done elsewhere; the has-ModRM decision arrives as an input.

Top module: `mrm_decode`

## Requirements
- R1: After reset, done_o, err_o, modrm_vld_o, sib_vld_o and rip_rel_o are 0, and disp_sz_o, disp_o, modrm_o, sib_o and next_off_o are 0.
- R2: done_o is 1 in the cycle after a cycle with start_i high, and 0 otherwise. All result outputs hold their values while start_i is low.
- R3: With has_modrm_i low, no byte is consumed. next_off_o equals off_i, every presence flag, disp_sz_o, disp_o and err_o are 0.
- R4: The ModRM byte is the window byte at off_i, with mod in bits [7:6] and r/m in bits [2:0]. A SIB byte is taken from off_i+1 only when the address size is not 16-bit, mod is not 3 and r/m is 4. addr_sz_i encodes 0 as 16-bit, 1 as 32-bit, 2 as 64-bit, and 3 behaves as 32-bit.
- R5: With mod equal to 3 the displacement size is 0 and disp_o is 0.
- R6: With mod equal to 1 a one-byte displacement follows for every address size. disp_o is that byte sign-extended.
- R7: With 16-bit addressing, a two-byte little-endian displacement follows when mod is 2, or when mod is 0 and r/m is 6. It is sign-extended; no other case carries a displacement.
- R8: With 32- or 64-bit addressing, a four-byte little-endian displacement follows in three cases: mod is 2; mod is 0 and r/m is 5; or a SIB is present with mod 0 and SIB base bits [2:0] equal to 5.
- R9: rip_rel_o is 1 exactly when mode64_i is high, a ModRM byte was decoded without error, and ModRM & 0xC7 equals 0x05.
- R10: next_off_o equals off_i plus one for the ModRM byte, plus one if a SIB is present, plus the displacement size.
- R11: Window byte k sits at win_i bits [8k+7:8k]. If off_i plus the bytes needed exceeds win_len_i (capped at the window size), err_o is 1. In that case every presence flag, rip_rel_o, disp_sz_o, disp_o, modrm_o and sib_o are 0, and next_off_o equals off_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Decode request, inputs valid |
| win_i | input | WIN_BYTES*8 | Instruction byte window, byte k at bits [8k+7:8k] |
| win_len_i | input | OFF_W | Count of valid bytes in the window |
| off_i | input | OFF_W | Offset of the byte after the opcode |
| has_modrm_i | input | 1 | A ModRM byte is expected |
| addr_sz_i | input | 2 | Address size: 0 16-bit, 1 32-bit, 2 64-bit |
| mode64_i | input | 1 | 64-bit mode |
| done_o | output | 1 | Result valid, one-cycle pulse |
| err_o | output | 1 | Needed byte outside the window |
| modrm_o | output | 8 | ModRM byte |
| modrm_vld_o | output | 1 | ModRM decoded |
| sib_o | output | 8 | SIB byte |
| sib_vld_o | output | 1 | SIB present |
| disp_sz_o | output | 3 | Displacement size in bytes: 0, 1, 2 or 4 |
| disp_o | output | 32 | Sign-extended displacement |
| rip_rel_o | output | 1 | Instruction-pointer-relative operand |
| next_off_o | output | OFF_W | Offset after the last decoded byte |

## Verification
Within one decode, the SIB base rule can extend the instruction at the same moment that the window-limit check fires. This happens when mod is 0 and the SIB base is 5, so a four-byte displacement pushes the end past the window. Directed cases shrink win_len_i one byte at a time around such an encoding. Each result is judged against the bench model: err_o with all fields cleared, or a full result with next_off_o at the window end. Random windows with random offsets, lengths and address sizes cover the same interplay for the mod 1, mod 2 and 16-bit rules.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

  typedef enum logic [1:0] {
    ASZ_16  = 2'd0,
    ASZ_32  = 2'd1,
    ASZ_64  = 2'd2,
    ASZ_RSV = 2'd3
  } asz_e;

  localparam int DISP_MAX = 4;
  localparam logic [1:0] MOD_REG = 2'd3;
  localparam logic [2:0] RM_SIB  = 3'd4;
  localparam logic [2:0] RM_D32  = 3'd5;
  localparam logic [2:0] RM_D16  = 3'd6;
  localparam logic [2:0] BASE_D32 = 3'd5;

  function automatic logic is_narrow(asz_e a);
    return a == ASZ_16;
  endfunction

endpackage

// File: rtl/mrm_byte_pick.sv
module mrm_byte_pick #(
  parameter int WIN_BYTES = 15,
  parameter int IDX_W     = 7
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [7:0]             byte_o
);
  // out-of-window index reads zero; the range check upstream flags it
  always_comb begin
    byte_o = '0;
    for (int k = 0; k < WIN_BYTES; k++) begin
      if (idx_i == IDX_W'(k)) byte_o = win_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/mrm_rule.sv
module mrm_rule
  import mrm_pkg::*;
(
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  input  asz_e       asz_i,
  output logic       sib_need_o,
  output logic [2:0] disp_sz_o
);
  logic [1:0] mod_w;
  logic [2:0] rm_w;
  logic [2:0] base_w;
  logic       narrow_w;

  assign mod_w    = modrm_i[7:6];
  assign rm_w     = modrm_i[2:0];
  assign base_w   = sib_i[2:0];
  assign narrow_w = is_narrow(asz_i);

  assign sib_need_o = !narrow_w && (mod_w != MOD_REG) && (rm_w == RM_SIB);

  always_comb begin
    disp_sz_o = 3'd0;
    unique case (mod_w)
      2'd1: disp_sz_o = 3'd1;
      2'd2: disp_sz_o = narrow_w ? 3'd2 : 3'd4;
      2'd0: begin
        if (narrow_w) begin
          if (rm_w == RM_D16) disp_sz_o = 3'd2;
        end else if (rm_w == RM_D32 || (sib_need_o && base_w == BASE_D32)) begin
          disp_sz_o = 3'd4;
        end
      end
      default: disp_sz_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/mrm_disp_ext.sv
module mrm_disp_ext
  import mrm_pkg::*;
(
  input  logic [DISP_MAX*8-1:0] raw_i,
  input  logic [2:0]            size_i,
  output logic [31:0]           value_o
);
  always_comb begin
    unique case (size_i)
      3'd1:    value_o = {{24{raw_i[7]}}, raw_i[7:0]};
      3'd2:    value_o = {{16{raw_i[15]}}, raw_i[15:0]};
      3'd4:    value_o = raw_i[31:0];
      default: value_o = '0;
    endcase
  end
endmodule

// File: rtl/mrm_decode.sv
module mrm_decode
  import mrm_pkg::*;
#(
  parameter int WIN_BYTES = 15,
  parameter int OFF_W     = $clog2(WIN_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [OFF_W-1:0]       win_len_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   has_modrm_i,
  input  logic [1:0]             addr_sz_i,
  input  logic                   mode64_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [7:0]             modrm_o,
  output logic                   modrm_vld_o,
  output logic [7:0]             sib_o,
  output logic                   sib_vld_o,
  output logic [2:0]             disp_sz_o,
  output logic [31:0]            disp_o,
  output logic                   rip_rel_o,
  output logic [OFF_W-1:0]       next_off_o
);
  localparam int CALC_W = OFF_W + 3;
  localparam logic [CALC_W-1:0] WIN_C = CALC_W'(WIN_BYTES);

  asz_e              asz_w;
  logic [CALC_W-1:0] base_w, lim_w, disp_idx_w, need_w, end_w;
  logic [7:0]        modrm_w, sib_w;
  logic              sib_need_w;
  logic [2:0]        dsz_w;
  logic [DISP_MAX*8-1:0] draw_w;
  logic [31:0]       dval_w;
  logic              err_w, rip_w;

  assign asz_w  = asz_e'(addr_sz_i);
  assign base_w = CALC_W'(off_i);
  assign lim_w  = (CALC_W'(win_len_i) > WIN_C) ? WIN_C : CALC_W'(win_len_i);

  mrm_byte_pick #(.WIN_BYTES(WIN_BYTES), .IDX_W(CALC_W)) u_pick_modrm (
    .win_i(win_i), .idx_i(base_w), .byte_o(modrm_w)
  );

  mrm_byte_pick #(.WIN_BYTES(WIN_BYTES), .IDX_W(CALC_W)) u_pick_sib (
    .win_i(win_i), .idx_i(base_w + CALC_W'(1)), .byte_o(sib_w)
  );

  mrm_rule u_rule (
    .modrm_i(modrm_w), .sib_i(sib_w), .asz_i(asz_w),
    .sib_need_o(sib_need_w), .disp_sz_o(dsz_w)
  );

  assign disp_idx_w = base_w + CALC_W'(1) + CALC_W'(sib_need_w);

  for (genvar g = 0; g < DISP_MAX; g++) begin : g_disp
    mrm_byte_pick #(.WIN_BYTES(WIN_BYTES), .IDX_W(CALC_W)) u_pick_d (
      .win_i(win_i), .idx_i(disp_idx_w + CALC_W'(g)), .byte_o(draw_w[g*8 +: 8])
    );
  end

  mrm_disp_ext u_ext (.raw_i(draw_w), .size_i(dsz_w), .value_o(dval_w));

  assign need_w = CALC_W'(1) + CALC_W'(sib_need_w) + CALC_W'(dsz_w);
  assign end_w  = base_w + need_w;
  assign err_w  = has_modrm_i && (end_w > lim_w);
  assign rip_w  = mode64_i && ((modrm_w & 8'hC7) == 8'h05);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      modrm_o     <= '0;
      modrm_vld_o <= 1'b0;
      sib_o       <= '0;
      sib_vld_o   <= 1'b0;
      disp_sz_o   <= '0;
      disp_o      <= '0;
      rip_rel_o   <= 1'b0;
      next_off_o  <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        if (!has_modrm_i || err_w) begin
          err_o       <= err_w;
          modrm_o     <= '0;
          modrm_vld_o <= 1'b0;
          sib_o       <= '0;
          sib_vld_o   <= 1'b0;
          disp_sz_o   <= '0;
          disp_o      <= '0;
          rip_rel_o   <= 1'b0;
          next_off_o  <= off_i;
        end else begin
          err_o       <= 1'b0;
          modrm_o     <= modrm_w;
          modrm_vld_o <= 1'b1;
          sib_o       <= sib_need_w ? sib_w : 8'h00;
          sib_vld_o   <= sib_need_w;
          disp_sz_o   <= dsz_w;
          disp_o      <= dval_w;
          rip_rel_o   <= rip_w;
          next_off_o  <= OFF_W'(end_w);
        end
      end
    end
  end

  // R2: done pulse tracks the request one cycle late
  assert_done_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_done_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(next_off_o) && $stable(disp_o)));
  // R4: a SIB is only reported for a memory form with r/m selecting it
  assert_sib_form_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sib_vld_o |-> (modrm_vld_o && modrm_o[7:6] != 2'd3 && modrm_o[2:0] == 3'd4));
  // R5: register form carries no displacement
  assert_reg_nodisp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modrm_vld_o && modrm_o[7:6] == 2'd3) |-> (disp_sz_o == 3'd0 && disp_o == 32'd0));
  // R6: byte displacement is sign-extended
  assert_byte_sext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_sz_o == 3'd1) |-> (disp_o[31:8] == {24{disp_o[7]}}));
  // R9: relative flag needs a decoded ModRM of the right shape
  assert_rip_shape_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rip_rel_o |-> (modrm_vld_o && (modrm_o & 8'hC7) == 8'h05));
  // R11: an error leaves no partial result
  assert_err_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!modrm_vld_o && !sib_vld_o && !rip_rel_o && disp_sz_o == 3'd0));

endmodule

// File: tb/mrm_decode_tb.sv
module mrm_decode_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 15;
  localparam int OW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [WB*8-1:0] win_i = '0;
  logic [OW-1:0] win_len_i = '0;
  logic [OW-1:0] off_i = '0;
  logic          has_modrm_i = 1'b0;
  logic [1:0]    addr_sz_i = '0;
  logic          mode64_i = 1'b0;
  logic          done_o, err_o, modrm_vld_o, sib_vld_o, rip_rel_o;
  logic [7:0]    modrm_o, sib_o;
  logic [2:0]    disp_sz_o;
  logic [31:0]   disp_o;
  logic [OW-1:0] next_off_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mrm_decode #(.WIN_BYTES(WB), .OFF_W(OW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .win_i(win_i),
    .win_len_i(win_len_i), .off_i(off_i), .has_modrm_i(has_modrm_i),
    .addr_sz_i(addr_sz_i), .mode64_i(mode64_i), .done_o(done_o), .err_o(err_o),
    .modrm_o(modrm_o), .modrm_vld_o(modrm_vld_o), .sib_o(sib_o), .sib_vld_o(sib_vld_o),
    .disp_sz_o(disp_sz_o), .disp_o(disp_o), .rip_rel_o(rip_rel_o), .next_off_o(next_off_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [WB*8-1:0] w, input int idx);
    return (idx >= 0 && idx < WB) ? w[idx*8 +: 8] : 8'h00;
  endfunction

  // expected results
  logic       e_err, e_mv, e_sv, e_rip;
  logic [7:0] e_m, e_s;
  int         e_dsz, e_next;
  logic [31:0] e_disp;

  task automatic model(input logic [WB*8-1:0] w, input int len, input int off,
                       input bit has, input int asz, input bit m64);
    int lim, nd, dst;
    logic [7:0] m, s;
    logic [1:0] md;
    logic [2:0] rm;
    bit sp, n16;
    logic [31:0] raw;
    lim = (len > WB) ? WB : len;
    e_err = 0; e_mv = 0; e_sv = 0; e_rip = 0; e_m = 0; e_s = 0;
    e_dsz = 0; e_disp = 0; e_next = off;
    if (!has) return;
    m = byte_at(w, off); md = m[7:6]; rm = m[2:0];
    n16 = (asz == 0);
    sp = !n16 && md != 2'd3 && rm == 3'd4;
    s = sp ? byte_at(w, off + 1) : 8'h00;
    if (md == 2'd3) nd = 0;
    else if (md == 2'd1) nd = 1;
    else if (n16) nd = (md == 2'd2 || rm == 3'd6) ? 2 : 0;
    else nd = (md == 2'd2 || rm == 3'd5 || (sp && s[2:0] == 3'd5)) ? 4 : 0;
    if (off + 1 + int'(sp) + nd > lim) begin
      e_err = 1;
      return;
    end
    dst = off + 1 + int'(sp);
    raw = {byte_at(w, dst + 3), byte_at(w, dst + 2), byte_at(w, dst + 1), byte_at(w, dst)};
    case (nd)
      1: e_disp = {{24{raw[7]}}, raw[7:0]};
      2: e_disp = {{16{raw[15]}}, raw[15:0]};
      4: e_disp = raw;
      default: e_disp = 0;
    endcase
    e_mv = 1; e_m = m; e_sv = sp; e_s = s; e_dsz = nd;
    e_next = off + 1 + int'(sp) + nd;
    e_rip = m64 && ((m & 8'hC7) == 8'h05);
  endtask

  task automatic run(input logic [WB*8-1:0] w, input int len, input int off,
                     input bit has, input int asz, input bit m64);
    string dreq;
    @(negedge clk_i);
    win_i = w; win_len_i = OW'(len); off_i = OW'(off); has_modrm_i = has;
    addr_sz_i = 2'(asz); mode64_i = m64; start_i = 1'b1;
    model(w, len, off, has, asz, m64);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2", "done", done_o, 1);
    if (e_err) begin
      chk("R11", "err", err_o, 1);
      chk("R11", "modrm_vld", modrm_vld_o, 0);
      chk("R11", "disp_sz", disp_sz_o, 0);
      chk("R11", "next_off", next_off_o, e_next);
      return;
    end
    if (!has) begin
      chk("R3", "err", err_o, 0);
      chk("R3", "modrm_vld", modrm_vld_o, 0);
      chk("R3", "next_off", next_off_o, e_next);
      chk("R3", "disp", disp_o, 0);
      return;
    end
    case (e_dsz)
      1: dreq = "R6";
      2: dreq = "R7";
      4: dreq = "R8";
      default: dreq = "R5";
    endcase
    chk("R11", "err", err_o, 0);
    chk("R4", "modrm", modrm_o, e_m);
    chk("R4", "sib_vld", sib_vld_o, e_sv);
    chk("R4", "sib", sib_o, e_s);
    chk(dreq, "disp_sz", disp_sz_o, e_dsz);
    chk(dreq, "disp", disp_o, e_disp);
    chk("R9", "rip_rel", rip_rel_o, e_rip);
    chk("R10", "next_off", next_off_o, e_next);
  endtask

  function automatic logic [WB*8-1:0] mk(input logic [7:0] b0, input logic [7:0] b1,
      input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5);
    logic [WB*8-1:0] w;
    w = {WB{8'hA5}};
    w[7:0] = b0; w[15:8] = b1; w[23:16] = b2; w[31:24] = b3; w[39:32] = b4; w[47:40] = b5;
    return w;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [WB*8-1:0] w;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 3);
    // R1: reset state
    chk("R1", "done", done_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "modrm_vld", modrm_vld_o, 0);
    chk("R1", "disp", disp_o, 0);
    chk("R1", "next_off", next_off_o, 0);
    rst_ni = 1'b1;

    // R3: no ModRM, even at window end
    run(mk(8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 3, 3, 0, 1, 1);
    // R5: register form
    run(mk(8'hC4, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 15, 0, 1, 1, 0);
    // R6: negative byte displacement in 16-bit and 64-bit
    run(mk(8'h46, 8'hF0, 8'h22, 8'h33, 8'h44, 8'h55), 15, 0, 1, 0, 0);
    run(mk(8'h00, 8'h41, 8'h80, 8'h33, 8'h44, 8'h55), 15, 1, 1, 2, 1);
    // R7: 16-bit forms
    run(mk(8'h06, 8'h34, 8'h92, 8'h33, 8'h44, 8'h55), 15, 0, 1, 0, 0);
    run(mk(8'h84, 8'h01, 8'h80, 8'h33, 8'h44, 8'h55), 15, 0, 1, 0, 0);
    run(mk(8'h04, 8'h01, 8'h80, 8'h33, 8'h44, 8'h55), 15, 0, 1, 0, 0);
    // R8: SIB base 5 with mod 0, and base not 5
    run(mk(8'h04, 8'h25, 8'h78, 8'h56, 8'h34, 8'hF2), 15, 0, 1, 1, 0);
    run(mk(8'h04, 8'h24, 8'h78, 8'h56, 8'h34, 8'hF2), 15, 0, 1, 2, 1);
    run(mk(8'h84, 8'h00, 8'h01, 8'h02, 8'h03, 8'h84), 15, 0, 1, 3, 0);
    // R9: relative form in and out of 64-bit mode
    run(mk(8'h3D, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h55), 15, 0, 1, 2, 1);
    run(mk(8'h3D, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h55), 15, 0, 1, 1, 0);
    // R11: window trimmed around SIB-base displacement
    for (int l = 0; l <= 7; l++)
      run(mk(8'h11, 8'h04, 8'h65, 8'h01, 8'h02, 8'h03) << 0, l, 1, 1, 1, 1);

    // R2: quiet cycles hold the result
    run(mk(8'h80, 8'h10, 8'h20, 8'h30, 8'h40, 8'h55), 15, 0, 1, 1, 0);
    @(negedge clk_i);
    chk("R2", "done_low", done_o, 0);
    chk("R2", "hold_next", next_off_o, e_next);
    chk("R2", "hold_disp", disp_o, e_disp);

    // random mix
    for (int i = 0; i < 600; i++) begin
      for (int b = 0; b < WB; b++) w[b*8 +: 8] = 8'($urandom);
      if ($urandom % 4 == 0) w[(($urandom % 8)*8) +: 8] = {2'($urandom), 6'b000_100};
      run(w, 8 + int'($urandom % 8), int'($urandom % 12), ($urandom % 8) != 0,
          int'($urandom % 4), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule